// File: doc/BRIEF.md
# Dual-Host Programmable Timer Bank

The block holds six independent 32-bit down-counting timers behind a single word-addressed register bus that two host processors share. Each timer counts at a 20 ns tick, which is one cycle of the 50 MHz block clock by default. It runs either once or repeatedly, and on expiry it raises a sticky flag. Each flag can interrupt either host, and the choice can be changed while the timer runs. Software can sample any timer's live count at any moment without disturbing it.

Each timer takes four words starting at word address `4*i`. Offset 0 is the reload value. Offset 1 is the control word. Offset 2 returns the live count and ignores writes. Offset 3 reads as zero. One status word at address `4*NUM_TMR` (24 for six timers) holds the expiry flags, with bit i belonging to timer i. A write of 1 to a status bit clears that flag.

Top module: `gp_timer_bank`

## Requirements
- R1: After reset every count, reload value, control word and status flag is zero, both interrupt outputs are low and `bus_rdata` is zero.
- R2: A control write whose bit 0 (run) goes from 0 to 1 loads the count from the reload register. The count then drops by one per tick, and the flag is set on the N-th tick after that write for a reload value N. With the default divider this is N cycles after the write edge.
- R3: A reload value of zero behaves as one, so the timer expires on the first tick.
- R4: With control bit 1 (repeat) at 0, expiry clears the run bit and leaves the count at zero.
- R5: With control bit 1 at 1, expiry reloads the count from the reload register. A reload value written while the timer runs is used at the next expiry.
- R6: Writing 1 to a status bit clears that flag and writing 0 leaves it. If a clear and an expiry of the same timer fall in one cycle, the flag stays set.
- R7: Control bit 3 steers a timer's flag to `irq_host_b` when 1 and to `irq_host_a` when 0. Control bit 2 enables the interrupt. Each output is the OR over its enabled, flagged timers.
- R8: A read returns the register value present in the cycle of the read on `bus_rdata` one cycle later, and it changes no timer state. `bus_rdata` changes only after a read.
- R9: While the run bit is 0 the count holds its value. A control write that clears the run bit stops counting from the next tick on.
- R10: Any reload value up to the full 32-bit value can be stored, read back and counted down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, 50 MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per word |
| bus_rd | input | 1 | Read strobe, one cycle per word |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after `bus_rd` |
| irq_host_a | output | 1 | Interrupt to host A |
| irq_host_b | output | 1 | Interrupt to host B |

## Verification
A write takes effect at the clock edge that samples it. The count loaded by a rising run bit is visible to a read issued in the very next cycle, and a flag, together with any interrupt it drives, rises on the edge of the N-th tick. Read data appears one edge after the strobe, so the driver queues each expected word while it issues the read, and the monitor pops it at the falling edge after the sampling edge. The interrupt checks are placed at the falling edge one cycle before and at the falling edge just after the edge where expiry is due. This catches both an early flag and a late one. The clear-versus-expiry case is timed so that the write lands exactly on an expiry edge of a timer that repeats every two ticks.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
    // Control word, bit 0 upward: run, repeat, interrupt enable, host select
    typedef struct packed {
        logic route_b;
        logic irq_en;
        logic periodic;
        logic en;
    } gpt_ctrl_t;

    localparam int unsigned REGS_PER_TMR = 4;
    localparam logic [1:0]  OFS_LOAD  = 2'd0;
    localparam logic [1:0]  OFS_CTRL  = 2'd1;
    localparam logic [1:0]  OFS_COUNT = 2'd2;
endpackage

// File: rtl/gpt_tick.sv
module gpt_tick #(
    parameter int unsigned DIV = 1
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q == CW'(DIV - 1));
        cnt_d = tick ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/gpt_channel.sv
module gpt_channel
    import gpt_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load_wr,
    input  logic [CNT_W-1:0] load_in,
    input  logic             ctrl_wr,
    input  gpt_ctrl_t        ctrl_in,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] load_val,
    output gpt_ctrl_t        ctrl,
    output logic [CNT_W-1:0] count,
    output logic             flag
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] load;
        gpt_ctrl_t        ctrl;
        logic             flag;
    } ch_state_t;

    ch_state_t        st_d, st_q;
    logic [CNT_W-1:0] reload;
    logic             expire;

    always_comb begin
        st_d   = st_q;
        reload = (st_q.load == '0) ? CNT_W'(1) : st_q.load;
        expire = st_q.ctrl.en && tick && (st_q.count <= CNT_W'(1));

        if (st_q.ctrl.en && tick) begin
            if (expire) begin
                if (st_q.ctrl.periodic) begin
                    st_d.count = reload;
                end else begin
                    st_d.count   = '0;
                    st_d.ctrl.en = 1'b0;
                end
            end else begin
                st_d.count = st_q.count - 1'b1;
            end
        end

        if (load_wr) st_d.load = load_in;

        if (ctrl_wr) begin
            st_d.ctrl = ctrl_in;
            if (ctrl_in.en && !st_q.ctrl.en) st_d.count = reload;
        end

        if (flag_clr) st_d.flag = 1'b0;
        if (expire)   st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign load_val = st_q.load;
    assign ctrl     = st_q.ctrl;
    assign count    = st_q.count;
    assign flag     = st_q.flag;

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl.en && tick && st_q.count > CNT_W'(1)) |=> (st_q.count == $past(st_q.count) - 1'b1));

    // R4
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !st_q.ctrl.periodic && !ctrl_wr) |=> (!st_q.ctrl.en && st_q.count == '0));

    // R5
    periodic_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && st_q.ctrl.periodic) |=>
            (st_q.count == (($past(st_q.load) == '0) ? CNT_W'(1) : $past(st_q.load))));

    // R6
    expiry_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> st_q.flag);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.ctrl.en && !ctrl_wr) |=> $stable(st_q.count));
endmodule

// File: rtl/gpt_irq_route.sv
module gpt_irq_route #(
    parameter int unsigned N = 6
) (
    input  logic [N-1:0] flags,
    input  logic [N-1:0] irq_en,
    input  logic [N-1:0] to_b,
    output logic         irq_a,
    output logic         irq_b
);
    logic [N-1:0] live;

    always_comb begin
        live  = flags & irq_en;
        irq_a = |(live & ~to_b);
        irq_b = |(live & to_b);
    end
endmodule

// File: rtl/gp_timer_bank.sv
module gp_timer_bank
    import gpt_pkg::*;
#(
    parameter int unsigned NUM_TMR  = 6,
    parameter int unsigned CNT_W    = 32,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned ADDR_W   = 5,
    parameter int unsigned TICK_DIV = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_host_a,
    output logic              irq_host_b
);
    localparam int unsigned IDX_W = ADDR_W - 2;
    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(NUM_TMR * REGS_PER_TMR);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } bank_state_t;

    bank_state_t      st_d, st_q;
    logic             tick;
    logic [NUM_TMR-1:0] flags, irq_en, to_b;
    logic [CNT_W-1:0] load_arr  [NUM_TMR];
    logic [CNT_W-1:0] count_arr [NUM_TMR];
    gpt_ctrl_t        ctrl_arr  [NUM_TMR];

    gpt_tick #(.DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
        localparam logic [ADDR_W-1:0] BASE = ADDR_W'(i * REGS_PER_TMR);
        logic load_wr, ctrl_wr, clr;

        assign load_wr = bus_wr && (bus_addr == (BASE | ADDR_W'(OFS_LOAD)));
        assign ctrl_wr = bus_wr && (bus_addr == (BASE | ADDR_W'(OFS_CTRL)));
        assign clr     = bus_wr && (bus_addr == STAT_ADDR) && bus_wdata[i];

        gpt_channel #(.CNT_W(CNT_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick),
            .load_wr  (load_wr),
            .load_in  (bus_wdata[CNT_W-1:0]),
            .ctrl_wr  (ctrl_wr),
            .ctrl_in  (gpt_ctrl_t'(bus_wdata[3:0])),
            .flag_clr (clr),
            .load_val (load_arr[i]),
            .ctrl     (ctrl_arr[i]),
            .count    (count_arr[i]),
            .flag     (flags[i])
        );

        assign irq_en[i] = ctrl_arr[i].irq_en;
        assign to_b[i]   = ctrl_arr[i].route_b;
    end

    gpt_irq_route #(.N(NUM_TMR)) u_route (
        .flags  (flags),
        .irq_en (irq_en),
        .to_b   (to_b),
        .irq_a  (irq_host_a),
        .irq_b  (irq_host_b)
    );

    always_comb begin
        st_d = st_q;
        if (bus_rd) begin
            st_d.rdata = '0;
            for (int i = 0; i < NUM_TMR; i++) begin
                if (bus_addr[ADDR_W-1:2] == IDX_W'(i)) begin
                    case (bus_addr[1:0])
                        OFS_LOAD:  st_d.rdata = DATA_W'(load_arr[i]);
                        OFS_CTRL:  st_d.rdata = DATA_W'({ctrl_arr[i]});
                        OFS_COUNT: st_d.rdata = DATA_W'(count_arr[i]);
                        default:   st_d.rdata = '0;
                    endcase
                end
            end
            if (bus_addr == STAT_ADDR) st_d.rdata = DATA_W'(flags);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;

    // R8
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    // R7
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags == '0) |-> (!irq_host_a && !irq_host_b));
endmodule

// File: tb/sim_gp_timer_bank.sv
module sim_gp_timer_bank;
    localparam int CLK_PERIOD = 20;
    localparam logic [4:0] STAT = 5'd24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_host_a, irq_host_b;

    int n_checks = 0;
    int n_fails  = 0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } rd_item_t;
    rd_item_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    gp_timer_bank u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .irq_host_a (irq_host_a),
        .irq_host_b (irq_host_b)
    );

    function automatic logic [4:0] ra(int tmr, int ofs);
        return 5'(tmr * 4 + ofs);
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Entry and exit at a falling edge; the write lands on the rising edge between.
    task automatic wr(logic [4:0] a, logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [4:0] a, logic [31:0] exp, string tag);
        rd_item_t it;
        it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    // Monitor: pops one expected word per sampled read strobe
    initial begin
        forever begin
            @(posedge clk);
            if (bus_rd) begin
                @(negedge clk);
                if (sb_q.size() == 0) begin
                    check("scoreboard underflow", 32'd1, 32'd0);
                end else begin
                    rd_item_t it;
                    it = sb_q.pop_front();
                    check(it.tag, bus_rdata, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        check("R1 irq_a", 32'(irq_host_a), 0);
        check("R1 irq_b", 32'(irq_host_b), 0);
        check("R1 rdata", bus_rdata, 0);
        rd(ra(0, 2), 0, "R1 count0");
        rd(STAT, 0, "R1 status");
        rd(ra(0, 1), 0, "R1 ctrl0");

        // R2 R8: timer 0, reload 10, one-shot, irq to host A
        wr(ra(0, 0), 32'd10);
        wr(ra(0, 1), 32'h5);
        rd(ra(0, 2), 32'd10, "R2 R8 count after load");
        rd(ra(0, 2), 32'd9,  "R2 count after one tick");
        check("R2 no early irq", 32'(irq_host_a), 0);
        idle(7);
        check("R2 irq one cycle before expiry", 32'(irq_host_a), 0);
        idle(1);
        check("R2 R8 irq at expiry", 32'(irq_host_a), 1);
        check("R7 host b quiet", 32'(irq_host_b), 0);
        rd(ra(0, 1), 32'h4, "R4 run bit cleared");
        rd(ra(0, 2), 32'd0, "R4 count left at zero");

        // R6 write-one-to-clear
        wr(STAT, 32'h0);
        rd(STAT, 32'h1, "R6 zero write keeps flag");
        wr(STAT, 32'h1);
        check("R6 irq after clear", 32'(irq_host_a), 0);
        rd(STAT, 32'h0, "R6 flag cleared");

        // R7 routing to host B
        wr(ra(1, 0), 32'd3);
        wr(ra(1, 1), 32'hD);
        idle(3);
        check("R7 irq_b raised", 32'(irq_host_b), 1);
        check("R7 irq_a untouched", 32'(irq_host_a), 0);

        // R3 zero reload expires on first tick; irq disabled
        wr(ra(2, 1), 32'h1);
        idle(1);
        rd(STAT, 32'h6, "R3 zero reload expired");
        check("R7 disabled irq gated", 32'(irq_host_a), 0);
        wr(STAT, 32'h3F);
        check("R6 clear all irq_b", 32'(irq_host_b), 0);

        // R5 periodic timer 3, reload 4
        wr(ra(3, 0), 32'd4);
        wr(ra(3, 1), 32'h7);
        idle(4);
        check("R5 first periodic expiry", 32'(irq_host_a), 1);
        rd(ra(3, 2), 32'd4, "R5 reloaded count");
        wr(STAT, 32'h8);
        check("R6 periodic flag cleared", 32'(irq_host_a), 0);
        wr(ra(3, 0), 32'd2);
        rd(ra(3, 2), 32'd1, "R5 count before expiry");
        check("R5 second expiry", 32'(irq_host_a), 1);
        rd(ra(3, 2), 32'd2, "R5 new reload used");
        wr(STAT, 32'h8);
        check("R6 expiry wins over clear", 32'(irq_host_a), 1);
        wr(STAT, 32'h8);
        check("R6 clear without expiry", 32'(irq_host_a), 0);

        // R9 stop timer 3 (write lands on an expiry edge)
        wr(ra(3, 1), 32'h6);
        rd(ra(3, 2), 32'd2, "R9 count after stop");
        idle(3);
        rd(ra(3, 2), 32'd2, "R9 count frozen");
        check("R9 last expiry flagged", 32'(irq_host_a), 1);
        wr(STAT, 32'h8);
        check("R9 cleared", 32'(irq_host_a), 0);

        // R10 full-range reload on the last timer
        wr(ra(5, 0), 32'hFFFF_FFFF);
        rd(ra(5, 0), 32'hFFFF_FFFF, "R10 reload readback");
        wr(ra(5, 1), 32'h1);
        rd(ra(5, 2), 32'hFFFF_FFFF, "R10 full count loaded");
        rd(ra(5, 2), 32'hFFFF_FFFE, "R10 full count steps");
        rd(ra(5, 3), 32'h0, "R8 spare word reads zero");

        idle(3);
        check("scoreboard drained", 32'(sb_q.size()), 0);
        finish_run();
    end
endmodule